// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how fast a low-frequency clock runs by counting cycles of a fast reference clock. A measurement window lasts a programmed number of slow-clock periods, and the number of reference cycles that pass inside it is the result. Firmware divides that count by the window length to get the slow-clock period in reference cycles. Four slow sources can be selected. In order of select code they are an internal RC oscillator, a 32.768 kHz crystal, a fast oscillator divided by 256, and whatever clock currently drives the system slow-clock mux. The divided fast oscillator uses the same logic as the other sources.

Each slow source goes through a two-flop synchronizer into the reference domain, followed by a rising-edge detector. A window opens on the first detected edge of the selected source. It closes on the edge that completes the programmed number of periods. The configuration is a small set of register fields, all written at once by a single write strobe: source select, window length, a start bit and a continuous-mode bit. In continuous mode, which is on out of reset, windows repeat with no gap between them. In one-shot mode, a rising edge on the start bit runs a single window.

The results are plain status pins: a ready flag and the latest count. They carry no handshake, so there is no back-pressure: a consumer reads them whenever it wants. The count is only replaced when a window completes.

Top module: `slowclk_cal`

## Requirements
- R1: After a completed window of N slow periods of P reference cycles each, `cal_value` equals N*P.
- R2: A window opens on the first rising edge of the selected source seen through the synchronizer after arming, so the result does not depend on the phase at which the measurement was armed.
- R3: After reset the continuous-mode bit is 1, the select is 0 and the window length is `RST_MAX`, so a measurement runs with no configuration write.
- R4: While continuous mode stays set, the edge that closes one window also opens the next one. A change of window length takes effect in the running measurement.
- R5: A one-shot measurement starts only on a 0-to-1 change of the start bit while the block is idle. Holding the bit high does not start another measurement.
- R6: The ready flag goes to 0 when a one-shot measurement starts and goes to 1 when any window completes. `cal_value` keeps its value until the next completion.
- R7: Select code k (0 to 3) measures `slow_clk[k]`.
- R8: A window length of 0 behaves as a length of 1.
- R9: A count that would exceed all-ones stays at all-ones (2^CNT_W - 1) and does not wrap.
- R10: If continuous mode is cleared during a window, that window completes and the block then goes idle, where it accepts a one-shot start.
- R11: During and right after reset, `cal_ready` is 0 and `cal_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | NUM_SRC | Slow clock sources, asynchronous to clk_ref |
| cfg_we | input | 1 | Write strobe: loads all four configuration fields |
| cfg_sel | input | clog2(NUM_SRC) | Slow source select |
| cfg_max | input | MAX_W | Window length in slow periods |
| cfg_start | input | 1 | One-shot start bit (rising edge triggers) |
| cfg_cont | input | 1 | Continuous-mode bit |
| cal_ready | output | 1 | Measurement complete flag |
| cal_value | output | CNT_W | Reference cycles counted in the last completed window |

## Verification
Some properties are checked on every cycle by assertions. A synchronized edge never lasts two cycles. The ready flag rises after every completion and falls after every accepted start. The result only moves on a completion. A saturated counter stays saturated. At the end of a window the block re-arms straight away or returns to idle, depending on the continuous bit. Other properties can only be shown by the bench scenarios, which compare against a cycle-level model. These are the exact counts for each source and window length, the reset defaults, ignoring a held start bit, the treatment of a zero length, and a live length change in continuous mode.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } cal_state_t;
endpackage

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/slowcal_ctrl.sv
module slowcal_ctrl
  import slowcal_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int MAX_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_edge,
  input  logic             start_lvl,
  input  logic             cont_en,
  input  logic [MAX_W-1:0] max_cyc,
  output logic             ready_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [MAX_W:0]   SLW_ONE = {{MAX_W{1'b0}}, 1'b1};

  cal_state_t       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [MAX_W-1:0] scnt_q;
  logic [MAX_W:0]   scnt_nx;
  logic             start_d, start_rise, fin;

  assign start_rise = start_lvl & ~start_d;
  assign cnt_inc    = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_ONE;
  assign scnt_nx    = {1'b0, scnt_q} + SLW_ONE;
  assign fin        = (state_q == ST_COUNT) && slow_edge && (scnt_nx >= {1'b0, max_cyc});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      scnt_q   <= '0;
      start_d  <= 1'b0;
      ready_o  <= 1'b0;
      result_o <= '0;
    end else begin
      start_d <= start_lvl;
      case (state_q)
        ST_IDLE: begin
          if (start_rise) begin
            ready_o <= 1'b0;
            state_q <= ST_ARM;
          end else if (cont_en) begin
            state_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (slow_edge) begin
            cnt_q   <= '0;
            scnt_q  <= '0;
            state_q <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (fin) begin
            result_o <= cnt_inc;
            ready_o  <= 1'b1;
            cnt_q    <= '0;
            scnt_q   <= '0;
            state_q  <= cont_en ? ST_COUNT : ST_IDLE;
          end else begin
            cnt_q <= cnt_inc;
            if (slow_edge) scnt_q <= scnt_nx[MAX_W-1:0];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READY_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> ready_o); // R6
  AST_READY_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_rise) |=> !ready_o); // R5
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(result_o)); // R6
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !fin && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP)); // R9
  AST_CONT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cont_en) |=> (state_q == ST_COUNT)); // R4
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !cont_en) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/slowclk_cal.sv
module slowclk_cal #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 20,
  parameter int MAX_W   = 15,
  parameter int SYNC_N  = 2,
  parameter int RST_MAX = 4
) (
  input  logic                       clk_ref,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         slow_clk,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_SRC)-1:0] cfg_sel,
  input  logic [MAX_W-1:0]           cfg_max,
  input  logic                       cfg_start,
  input  logic                       cfg_cont,
  output logic                       cal_ready,
  output logic [CNT_W-1:0]           cal_value
);
  localparam int SEL_W = $clog2(NUM_SRC);
  localparam logic [MAX_W-1:0] MAX_RST = MAX_W'(RST_MAX);

  logic [SEL_W-1:0]   sel_q;
  logic [MAX_W-1:0]   max_q;
  logic               start_q, cont_q;
  logic [NUM_SRC-1:0] src_rise;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      max_q   <= MAX_RST;
      start_q <= 1'b0;
      cont_q  <= 1'b1;
    end else if (cfg_we) begin
      sel_q   <= cfg_sel;
      max_q   <= cfg_max;
      start_q <= cfg_start;
      cont_q  <= cfg_cont;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    slowcal_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .async_in (slow_clk[g]),
      .rise_o   (src_rise[g])
    );
  end

  slowcal_ctrl #(.CNT_W(CNT_W), .MAX_W(MAX_W)) u_ctrl (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .slow_edge (src_rise[sel_q]),
    .start_lvl (start_q),
    .cont_en   (cont_q),
    .max_cyc   (max_q),
    .ready_o   (cal_ready),
    .result_o  (cal_value)
  );

  AST_CFG_HOLDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cfg_we |=> ($stable(cont_q) && $stable(max_q) && $stable(sel_q))); // R3
endmodule

// File: tb/slowclk_cal_bench.sv
module slowclk_cal_bench;
  localparam int CW   = 8;
  localparam int MW   = 15;
  localparam int RMAX = 4;
  localparam int CTOP = (1 << CW) - 1;
  localparam int P0 = 10, P1 = 14, P2 = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    slow_clk = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [MW-1:0] cfg_max = '0;
  logic          cfg_start = 1'b0;
  logic          cfg_cont = 1'b0;
  logic          cal_ready;
  logic [CW-1:0] cal_value;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ph0 = 0, ph1 = 0, ph2 = 0;
  string phase_req = "R3";

  always #2 clk = ~clk;

  slowclk_cal #(.NUM_SRC(4), .CNT_W(CW), .MAX_W(MW), .SYNC_N(2), .RST_MAX(RMAX)) u_slowclk_cal (
    .clk_ref(clk), .rst_n(rst_n), .slow_clk(slow_clk), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_max(cfg_max), .cfg_start(cfg_start), .cfg_cont(cfg_cont),
    .cal_ready(cal_ready), .cal_value(cal_value));

  // slow sources, stepped on the falling reference edge; source 3 follows source 2
  always @(negedge clk) begin
    ph0 = (ph0 + 1) % P0; ph1 = (ph1 + 1) % P1; ph2 = (ph2 + 1) % P2;
    slow_clk[0] <= (ph0 < P0 / 2);
    slow_clk[1] <= (ph1 < P1 / 2);
    slow_clk[2] <= (ph2 < P2 / 2);
    slow_clk[3] <= (ph2 < P2 / 2);
  end

  // behavioural reference model
  int   m_state, m_cnt, m_scnt, m_res, m_max;
  bit   m_rdy, m_start, m_startd, m_cont;
  bit [1:0] m_sel;
  bit [3:0] h1, h2, h3;
  always @(posedge clk) begin
    bit e, rise, fin;
    int inc;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_scnt = 0; m_res = 0; m_rdy = 0;
      m_max = RMAX; m_sel = 0; m_start = 0; m_startd = 0; m_cont = 1;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      e    = h2[m_sel] & ~h3[m_sel];
      rise = m_start & ~m_startd;
      inc  = (m_cnt >= CTOP) ? CTOP : m_cnt + 1;
      fin  = (m_state == 2) && e && (m_scnt + 1 >= m_max);
      if (m_state == 0) begin
        if (rise) begin m_rdy = 0; m_state = 1; end
        else if (m_cont) m_state = 1;
      end else if (m_state == 1) begin
        if (e) begin m_cnt = 0; m_scnt = 0; m_state = 2; end
      end else begin
        if (fin) begin
          m_res = inc; m_rdy = 1; m_cnt = 0; m_scnt = 0;
          m_state = m_cont ? 2 : 0;
        end else begin
          m_cnt = inc;
          if (e) m_scnt = m_scnt + 1;
        end
      end
      m_startd = m_start;
      if (cfg_we) begin
        m_sel = cfg_sel; m_max = int'(cfg_max); m_start = cfg_start; m_cont = cfg_cont;
      end
      h3 = h2; h2 = h1; h1 = slow_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cal_ready == m_rdy, {phase_req, " ready vs model"}, int'(cal_ready), int'(m_rdy));
      chk(int'(cal_value) == m_res, {phase_req, " value vs model"}, int'(cal_value), m_res);
    end
  end

  task automatic cfg(input int sel, input int mx, input bit st, input bit ct);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_max = MW'(mx); cfg_start = st; cfg_cont = ct;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !cal_ready; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic oneshot(input int sel, input int mx, input int exp, input string req);
    cfg(sel, mx, 1'b0, 1'b0);
    cfg(sel, mx, 1'b1, 1'b0);
    @(negedge clk);
    chk(cal_ready == 1'b0, "R6 ready cleared at start", int'(cal_ready), 0);
    wait_ready();
    @(negedge clk);
    chk(cal_ready == 1'b1, {req, " completion"}, int'(cal_ready), 1);
    chk(int'(cal_value) == exp, {req, " count"}, int'(cal_value), exp);
  endtask

  initial begin
    idle(5);
    chk(cal_ready == 1'b0, "R11 ready in reset", int'(cal_ready), 0);
    chk(cal_value == '0, "R11 value in reset", int'(cal_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_ready == 1'b0, "R11 ready after reset", int'(cal_ready), 0);
    phase_req = "R3";
    wait_ready();
    @(negedge clk);
    chk(int'(cal_value) == RMAX * P0, "R3 default continuous count", int'(cal_value), RMAX * P0);

    phase_req = "R10";
    cfg(0, 4, 1'b0, 1'b0);
    idle(200);
    cfg(0, 4, 1'b1, 1'b0);
    @(negedge clk);
    chk(cal_ready == 1'b0, "R10 idle after stop accepts start", int'(cal_ready), 0);
    wait_ready();
    @(negedge clk);
    chk(int'(cal_value) == 40, "R1 one-shot count", int'(cal_value), 40);

    phase_req = "R5";
    idle(300);
    chk(cal_ready == 1'b1, "R5 held start no retrigger", int'(cal_ready), 1);

    phase_req = "R7";
    oneshot(1, 3, 3 * P1, "R7 sel1");
    oneshot(2, 2, 2 * P2, "R7 sel2");
    oneshot(3, 5, 5 * P2, "R7 sel3");
    phase_req = "R2";
    oneshot(0, 7, 7 * P0, "R2 arm phase");
    phase_req = "R8";
    oneshot(0, 0, P0, "R8 zero length");
    phase_req = "R9";
    oneshot(2, 20, CTOP, "R9 saturation");

    phase_req = "R4";
    cfg(1, 2, 1'b0, 1'b1);
    idle(120);
    chk(int'(cal_value) == 2 * P1, "R4 continuous count", int'(cal_value), 2 * P1);
    cfg(1, 3, 1'b0, 1'b1);
    idle(150);
    chk(int'(cal_value) == 3 * P1, "R4 live length change", int'(cal_value), 3 * P1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule